// File: doc/BRIEF.md
# S/PDIF Input Rate Classifier

This block sits in a fast reference-clock domain next to a biphase-mark coded serial audio input. It works out which of seven standard sample rates the incoming stream carries. The rates are 32000, 44100, 48000, 88200, 96000, 176400 and 192000 Hz, and they are numbered 0 to 6. The block does not decode frames. It brings the input into its clock domain, times every interval between two input transitions, and keeps the shortest and the longest interval over a measurement window of programmable length.

When each window closes, the block compares twice the chosen interval against a ladder of programmable thresholds and reports the mode it finds. It also reports the widest interval of that window. If the window held no transitions, it reports "no signal". A change of mode sets a sticky event flag, and that flag drives a maskable interrupt line.

Software configures the block through a narrow write-only port. For a reference clock of frequency F, the nominal shortest pulse of mode m is F / (128 × rate_m). The threshold of mode m is its own nominal value plus the nominal value of mode m+1. The window length is normally F / 1000, which gives one result per millisecond.

Top module: `spdif_rate_sense`

## Requirements
- R1: While `rst` is high at a clock edge, the block sets `mode_o` to 7, `max_width_o` to 0 and `irq_stat_o` to 0, so `irq_o` is low.
- R2: `serial_in` passes through a two-stage synchronizer. The width of an interval is the number of clock cycles between two consecutive transitions. The width saturates at 1023.
- R3: Write address 0 sets the window length in clock cycles (20 bits). Setting `en` high starts a fresh window, and `mode_o` and `max_width_o` change only in the cycle that closes a window. The first update comes exactly one window length after the first enabled edge.
- R4: Write addresses 4 to 9 hold the 10-bit thresholds of modes 0 to 5. The block chooses the lowest mode m whose threshold is strictly less than twice the classification width. If no threshold is exceeded, the mode is 6.
- R5: Bit 0 of write address 1 selects the classification width: 1 (the reset value) selects the narrowest interval of the window, and 0 selects the widest.
- R6: A window with no transition reports mode 7 and a maximum width of 0. Mode 7 and a width of 0 always occur together.
- R7: `max_width_o` reports the widest interval of the last closed window.
- R8: Bit 2 of `irq_stat_o` is set when a window closes with a mode different from the current one. It stays set until software writes a 1 to bit 2 at address 3. If the bit is set and cleared in the same cycle, setting wins. A window that closes with the same mode sets nothing.
- R9: Write address 2 holds an 8-bit mask. `irq_o` is high exactly when some status bit and its mask bit are both 1.
- R10: While `en` is low, measurement stops, the window timer and interval trackers are cleared, and `mode_o`, `max_width_o` and `irq_stat_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Measurement enable |
| serial_in | input | 1 | Asynchronous biphase-mark input |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 20 | Register write data |
| mode_o | output | 3 | Detected rate mode, 7 = no signal |
| max_width_o | output | 10 | Widest interval in last window |
| irq_stat_o | output | 8 | Sticky event flags (bit 2 = mode change) |
| irq_o | output | 1 | Masked interrupt request |

## Verification
The hardest point to reach from the ports is the exact window boundary. The window phase is internal and normally free-running, so a check cannot know in which cycle a result will appear. The bench gets around this by holding `en` low, which zeroes the window timer. It then raises `en` at a known edge and samples `mode_o` one cycle before and one cycle after the predicted closing edge. The threshold priority order is reached with a deliberately non-monotonic threshold ladder. Width saturation is reached with an input whose transitions are spaced further apart than the counter range but still fall inside each window.

// File: rtl/spdr_pkg.sv
package spdr_pkg;

    typedef logic [2:0] mode_t;

    localparam mode_t MODE_NONE = 3'd7;

    // write-port register addresses
    localparam int ADDR_WIN  = 0;
    localparam int ADDR_CTRL = 1;
    localparam int ADDR_MASK = 2;
    localparam int ADDR_STAT = 3;
    localparam int ADDR_THR0 = 4;

    // event-flag bit raised on a mode change
    localparam int CHG_BIT = 2;

endpackage

// File: rtl/spdr_sync_edge.sv
module spdr_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic edge_o
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[SH_W-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= sh_d;
    end

    // previous synchronized sample vs current synchronized sample
    assign edge_o = sh_q[SH_W-1] ^ sh_q[SH_W-2];

endmodule

// File: rtl/spdr_width_meter.sv
module spdr_width_meter #(
    parameter int WID_W = 10,
    parameter int WIN_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             edge_i,
    input  logic [WIN_W-1:0] win_len,
    output logic             win_end_o,
    output logic [WID_W-1:0] win_min_o,
    output logic [WID_W-1:0] win_max_o,
    output logic             win_seen_o
);
    localparam logic [WID_W-1:0] WID_MAX = {WID_W{1'b1}};

    typedef struct packed {
        logic [WID_W-1:0] cnt;
        logic [WIN_W-1:0] tick;
        logic [WID_W-1:0] wmin;
        logic [WID_W-1:0] wmax;
        logic             seen;
    } meter_t;

    localparam meter_t METER_CLR = '{cnt: '0, tick: '0, wmin: WID_MAX,
                                     wmax: '0, seen: 1'b0};

    meter_t m_d, m_q;
    logic [WID_W-1:0] width;
    logic             win_end;

    always_comb begin
        width   = (m_q.cnt == WID_MAX) ? WID_MAX : m_q.cnt + 1'b1;
        win_end = (win_len != '0) && (m_q.tick >= win_len - 1'b1);
        m_d     = m_q;

        if (edge_i)                 m_d.cnt = '0;
        else if (m_q.cnt != WID_MAX) m_d.cnt = m_q.cnt + 1'b1;

        if (win_len == '0)  m_d.tick = '0;
        else if (win_end)   m_d.tick = '0;
        else                m_d.tick = m_q.tick + 1'b1;

        if (win_end) begin
            // current edge opens the new window
            m_d.wmin = edge_i ? width : WID_MAX;
            m_d.wmax = edge_i ? width : '0;
            m_d.seen = edge_i;
        end else if (edge_i) begin
            if (width < m_q.wmin) m_d.wmin = width;
            if (width > m_q.wmax) m_d.wmax = width;
            m_d.seen = 1'b1;
        end

        if (!en) m_d = METER_CLR;
    end

    always_ff @(posedge clk) begin
        if (rst) m_q <= METER_CLR;
        else     m_q <= m_d;
    end

    assign win_end_o  = en && win_end;
    assign win_min_o  = m_q.wmin;
    assign win_max_o  = m_q.wmax;
    assign win_seen_o = m_q.seen;

endmodule

// File: rtl/spdr_mode_pick.sv
module spdr_mode_pick
    import spdr_pkg::*;
#(
    parameter int WID_W = 10,
    parameter int THR_W = 10,
    parameter int NTHR  = 6
) (
    input  logic [WID_W-1:0]            metric,
    input  logic [NTHR-1:0][THR_W-1:0]  thr,
    output mode_t                       mode_o
);
    localparam int CW = ((WID_W + 1) > THR_W) ? (WID_W + 1) : THR_W;

    logic [CW-1:0]   twice;
    logic [NTHR-1:0] hit;

    assign twice = CW'({metric, 1'b0});

    for (genvar g = 0; g < NTHR; g++) begin : g_rung
        assign hit[g] = twice > CW'(thr[g]);
    end

    always_comb begin
        mode_o = mode_t'(NTHR);
        for (int i = NTHR - 1; i >= 0; i--) begin
            if (hit[i]) mode_o = mode_t'(i);
        end
    end

endmodule

// File: rtl/spdif_rate_sense.sv
module spdif_rate_sense
    import spdr_pkg::*;
#(
    parameter int WIN_W       = 20,
    parameter int WID_W       = 10,
    parameter int THR_W       = 10,
    parameter int NMODE       = 7,
    parameter int IRQ_W       = 8,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2,
    parameter int DEF_WIN     = 333333
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              serial_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIN_W-1:0]  wr_data,
    output logic [2:0]        mode_o,
    output logic [WID_W-1:0]  max_width_o,
    output logic [IRQ_W-1:0]  irq_stat_o,
    output logic              irq_o
);
    localparam int NTHR = NMODE - 1;

    typedef struct packed {
        logic [WIN_W-1:0]           win_len;
        logic                       sel_min;
        logic [IRQ_W-1:0]           mask;
        logic [NTHR-1:0][THR_W-1:0] thr;
        mode_t                      mode;
        logic [WID_W-1:0]           maxw;
        logic [IRQ_W-1:0]           stat;
    } regs_t;

    localparam regs_t REGS_RST = '{win_len: WIN_W'(DEF_WIN), sel_min: 1'b1,
                                   mask: '0, thr: '0, mode: MODE_NONE,
                                   maxw: '0, stat: '0};

    regs_t r_d, r_q;

    logic             edge_w;
    logic             win_end;
    logic [WID_W-1:0] win_min, win_max;
    logic             win_seen;
    mode_t            picked;
    logic [WID_W-1:0] metric;

    spdr_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .din    (serial_in),
        .edge_o (edge_w)
    );

    spdr_width_meter #(.WID_W(WID_W), .WIN_W(WIN_W)) u_meter (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .edge_i     (edge_w),
        .win_len    (r_q.win_len),
        .win_end_o  (win_end),
        .win_min_o  (win_min),
        .win_max_o  (win_max),
        .win_seen_o (win_seen)
    );

    assign metric = r_q.sel_min ? win_min : win_max;

    spdr_mode_pick #(.WID_W(WID_W), .THR_W(THR_W), .NTHR(NTHR)) u_pick (
        .metric (metric),
        .thr    (r_q.thr),
        .mode_o (picked)
    );

    always_comb begin
        mode_t            nxt_mode;
        logic [WID_W-1:0] nxt_max;

        r_d      = r_q;
        nxt_mode = win_seen ? picked : MODE_NONE;
        nxt_max  = win_seen ? win_max : '0;

        if (wr_en) begin
            if (wr_addr == ADDR_W'(ADDR_WIN))  r_d.win_len = wr_data;
            if (wr_addr == ADDR_W'(ADDR_CTRL)) r_d.sel_min = wr_data[0];
            if (wr_addr == ADDR_W'(ADDR_MASK)) r_d.mask    = wr_data[IRQ_W-1:0];
            if (wr_addr == ADDR_W'(ADDR_STAT)) r_d.stat    = r_q.stat & ~wr_data[IRQ_W-1:0];
            for (int i = 0; i < NTHR; i++) begin
                if (wr_addr == ADDR_W'(ADDR_THR0 + i)) r_d.thr[i] = wr_data[THR_W-1:0];
            end
        end

        if (win_end) begin
            if (nxt_mode != r_q.mode) r_d.stat[CHG_BIT] = 1'b1;
            r_d.mode = nxt_mode;
            r_d.maxw = nxt_max;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= REGS_RST;
        else     r_q <= r_d;
    end

    assign mode_o      = r_q.mode;
    assign max_width_o = r_q.maxw;
    assign irq_stat_o  = r_q.stat;
    assign irq_o       = |(r_q.stat & r_q.mask);

endmodule

// File: rtl/spdr_checker.sv
module spdr_checker (
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic [2:0] mode_o,
    input logic [9:0] max_width_o,
    input logic [7:0] irq_stat_o,
    input logic       irq_o
);
    // R1: outputs cleared after a reset edge
    p_reset_state_r1: assert property (@(posedge clk)
        $past(rst) |-> (mode_o == 3'd7 && max_width_o == '0 && irq_stat_o == '0));

    // R6: no-signal mode and zero width go together
    p_nosig_pair_r6: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 3'd7) == (max_width_o == '0));

    // R8: a new mode always leaves the change flag set
    p_change_flag_r8: assert property (@(posedge clk) disable iff (rst)
        (mode_o != $past(mode_o)) |-> irq_stat_o[2]);

    // R9: the only event source is the change flag
    p_irq_source_r9: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> irq_stat_o[2]);

    // R10: results frozen while disabled
    p_hold_off_r10: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(mode_o) && $stable(max_width_o) && $stable(irq_stat_o)));

endmodule

bind spdif_rate_sense spdr_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .mode_o      (mode_o),
    .max_width_o (max_width_o),
    .irq_stat_o  (irq_stat_o),
    .irq_o       (irq_o)
);

// File: tb/sim_spdif_rate_sense.sv
module sim_spdif_rate_sense;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        serial_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [19:0] wr_data = '0;
    logic [2:0]  mode_o;
    logic [9:0]  max_width_o;
    logic [7:0]  irq_stat_o;
    logic        irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // stimulus generator: 0 silent, 1 biphase-like N,N,2N, 2 square every N
    int gen_kind = 0;
    int gen_n    = 10;

    always #2 clk = ~clk;

    spdif_rate_sense u0 (
        .clk         (clk),
        .rst         (rst),
        .en          (en),
        .serial_in   (serial_in),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .mode_o      (mode_o),
        .max_width_o (max_width_o),
        .irq_stat_o  (irq_stat_o),
        .irq_o       (irq_o)
    );

    initial begin
        int gcnt = 0;
        int gph  = 0;
        forever begin
            int w;
            @(negedge clk);
            if (gen_kind != 0) begin
                w = (gen_kind == 2) ? gen_n : ((gph == 2) ? 2 * gen_n : gen_n);
                gcnt++;
                if (gcnt >= w) begin
                    serial_in = ~serial_in;
                    gcnt = 0;
                    gph = (gph + 1) % 3;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = 4'(addr);
        wr_data = 20'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load_ladder();
        // nominal widths 81,59,54,29,27,14,13 -> thresholds
        wr(4, 140); wr(5, 113); wr(6, 83);
        wr(7, 56);  wr(8, 41);  wr(9, 27);
    endtask

    task automatic t_reset();
        chk(mode_o == 3'd7, "R1 mode", int'(mode_o), 7);
        chk(max_width_o == 0, "R1 maxw", int'(max_width_o), 0);
        chk(irq_stat_o == 0, "R1 stat", int'(irq_stat_o), 0);
        chk(irq_o == 1'b0, "R1 irq", int'(irq_o), 0);
    endtask

    task automatic t_rates();
        int noms[7] = '{81, 59, 54, 29, 27, 14, 13};
        for (int i = 0; i < 7; i++) begin
            gen_kind = 1;
            gen_n = noms[i];
            wait_cyc(6000);
            chk(mode_o == 3'(i), "R4 mode per rate", int'(mode_o), i);
            chk(max_width_o == 10'(2 * noms[i]), "R7 max width", int'(max_width_o), 2 * noms[i]);
            if (i == 0) chk(irq_stat_o[2] == 1'b1, "R8 change flag", int'(irq_stat_o[2]), 1);
        end
    endtask

    task automatic t_irq();
        chk(irq_o == 1'b0, "R9 masked", int'(irq_o), 0);
        wr(2, 4);
        chk(irq_o == 1'b1, "R9 unmasked", int'(irq_o), 1);
        wr(3, 4);
        chk(irq_stat_o[2] == 1'b0, "R8 w1c", int'(irq_stat_o[2]), 0);
        chk(irq_o == 1'b0, "R9 after clear", int'(irq_o), 0);
        wait_cyc(5000);
        chk(irq_stat_o[2] == 1'b0, "R8 steady no event", int'(irq_stat_o[2]), 0);
    endtask

    task automatic t_order();
        gen_kind = 1;
        gen_n = 29;
        wr(4, 1023); wr(5, 50); wr(6, 40); wr(7, 30); wr(8, 20); wr(9, 10);
        wait_cyc(6000);
        chk(mode_o == 3'd1, "R4 priority order", int'(mode_o), 1);
        load_ladder();
        wait_cyc(6000);
        chk(mode_o == 3'd3, "R4 restored ladder", int'(mode_o), 3);
    endtask

    task automatic t_widthsel();
        wr(1, 0);
        wait_cyc(6000);
        chk(mode_o == 3'd1, "R5 widest select", int'(mode_o), 1);
        wr(1, 1);
        wait_cyc(6000);
        chk(mode_o == 3'd3, "R5 narrowest select", int'(mode_o), 3);
    endtask

    task automatic t_sat();
        gen_kind = 2;
        gen_n = 1500;
        wait_cyc(8000);
        chk(max_width_o == 10'd1023, "R2 saturate", int'(max_width_o), 1023);
        chk(mode_o == 3'd0, "R2 saturated mode", int'(mode_o), 0);
    endtask

    task automatic t_disable();
        @(negedge clk);
        en = 1'b0;
        gen_kind = 1;
        gen_n = 13;
        wait_cyc(6000);
        chk(mode_o == 3'd0, "R10 mode held", int'(mode_o), 0);
        chk(max_width_o == 10'd1023, "R10 maxw held", int'(max_width_o), 1023);
    endtask

    task automatic t_window();
        wr(0, 700);
        @(negedge clk);
        en = 1'b1;
        // first enabled edge is E0; the window closes at E699
        wait_cyc(699);
        chk(mode_o == 3'd0, "R3 before window end", int'(mode_o), 0);
        wait_cyc(1);
        chk(mode_o == 3'd6, "R3 at window end", int'(mode_o), 6);
        chk(max_width_o == 10'd26, "R7 first window max", int'(max_width_o), 26);
    endtask

    task automatic t_nosig();
        wr(3, 4);
        gen_kind = 0;
        wait_cyc(2500);
        chk(mode_o == 3'd7, "R6 no signal mode", int'(mode_o), 7);
        chk(max_width_o == 0, "R6 no signal maxw", int'(max_width_o), 0);
        chk(irq_stat_o[2] == 1'b1, "R8 flag on loss", int'(irq_stat_o[2]), 1);
        chk(irq_o == 1'b1, "R9 irq on loss", int'(irq_o), 1);
    endtask

    initial begin
        wait_cyc(5);
        t_reset();
        @(negedge clk);
        rst = 1'b0;
        wr(0, 2000);
        load_ladder();
        @(negedge clk);
        en = 1'b1;
        t_rates();
        t_irq();
        t_order();
        t_widthsel();
        t_sat();
        t_disable();
        t_window();
        t_nosig();
        finished = 1'b1;
    end

    initial begin
        for (int c = 0; c < 190000; c++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule